// File: doc/BRIEF.md
# Unified Rotate-Path Barrel Shifter

This block is a purely combinational 32-bit shift and rotate unit for an execution pipeline. From one operand, a 5-bit distance and three control bits it produces, in the same cycle, any of five results: rotate right, rotate left, logical shift left, logical shift right and arithmetic shift right.

All bit movement goes through a single cascade of five rotate-right stages, of 1, 2, 4, 8 and 16 positions. A left operation by K is turned into a right rotation by (32 − K) mod 32. The control logic complements the distance bits that feed the cascade, which gives 31 − K, and a fixed one-position right rotation then adds the missing step. For shifts, a mask built from the distance keeps the valid lanes of the rotated word. The cleared lanes are filled with zeros, or with the operand's top bit for an arithmetic right shift. Rotations take the unmasked cascade output. A final select chooses between the two paths.

Control encoding: `rotSel`=1 selects a rotation and 0 selects a shift. `dirLeft`=1 selects left and 0 selects right. `arith`=1 requests sign fill, and it only acts on a right shift with `rotSel`=0.

Top module: `rot_barrel_shifter`

## Requirements
- R1: With rotSel=1 and dirLeft=0, result equals operand rotated right by amount K: result bit i is operand bit (i+K) mod 32.
- R2: With rotSel=1 and dirLeft=1, result equals operand rotated left by K: result bit i is operand bit (i−K) mod 32.
- R3: With rotSel=0, dirLeft=0 and arith=0, result is operand shifted right by K, and the upper K result bits are 0.
- R4: With rotSel=0, dirLeft=0 and arith=1, result is operand shifted right by K, and the upper K result bits equal operand bit 31.
- R5: With rotSel=0 and dirLeft=1, result is operand shifted left by K, and the lower K result bits are 0.
- R6: An amount of 0 returns the operand unchanged for all five operations.
- R7: A rotation in either direction preserves the number of one bits of the operand.
- R8: The arith input has no effect when rotSel=1 or when dirLeft=1.
- R9: The result is valid in the same cycle as the inputs. No register lies on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Data word to be moved |
| amount | input | 5 | Shift or rotate distance K |
| rotSel | input | 1 | 1 = rotate, 0 = shift |
| dirLeft | input | 1 | 1 = left, 0 = right |
| arith | input | 1 | 1 = sign fill on a right shift |
| result | output | 32 | Shifted or rotated word |

## Verification
Every one of the five operations is driven with every distance from 0 to 31. The operands come from fixed-seed random words mixed with the patterns all-zeros, all-ones, 0x8000_0000, 0x0000_0001 and 0x7FFF_FFFF.

The single-bit operands show where a lane lands, so an off-by-one in the left-direction remap, or a stage wired to the wrong amount bit, shows up at once. The all-ones and top-bit patterns separate zero fill from sign fill and expose a mask edge that is off by one position. Random words catch crossed lanes in the middle of the word.

Rotations and left shifts are repeated with arith set to 1, to show that this input has no effect on them.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int WIDTH = 32;
  localparam int AMT_W = $clog2(WIDTH);

  // Strobes handed from control to datapath
  typedef struct packed {
    logic [AMT_W-1:0] coreAmt;    // distance applied by the rotate cascade
    logic [AMT_W-1:0] maskAmt;    // original distance, used for the mask
    logic             extraRot;   // add one more right step after the cascade
    logic             maskLeft;   // mask clears low lanes instead of high lanes
    logic             signFill;   // cleared lanes take ones
    logic             takeRotate; // select the unmasked path
  } shiftCtrl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic [AMT_W-1:0] amount,
  input  logic             rotSel,
  input  logic             dirLeft,
  input  logic             arith,
  input  logic             signBit,
  output shiftCtrl_t       ctrl
);
  always_comb begin
    // a left move by K becomes a right rotation by ~K, plus one extra step
    ctrl.coreAmt    = dirLeft ? ~amount : amount;
    ctrl.maskAmt    = amount;
    ctrl.extraRot   = dirLeft;
    ctrl.maskLeft   = dirLeft;
    ctrl.signFill   = !rotSel && !dirLeft && arith && signBit;
    ctrl.takeRotate = rotSel;
  end
endmodule

// File: rtl/shift_maskgen.sv
module shift_maskgen
  import shift_pkg::*;
(
  input  logic [AMT_W-1:0] maskAmt,
  input  logic             maskLeft,
  output logic [WIDTH-1:0] keepMask
);
  logic [WIDTH-1:0] stage [0:AMT_W];
  logic [WIDTH-1:0] rightMask;
  logic [WIDTH-1:0] leftMask;

  assign stage[0] = '1;

  // zero-filling right shifts of an all-ones seed give the right-shift mask
  for (genvar i = 0; i < AMT_W; i++) begin : g_mstage
    localparam int SH = 1 << i;
    assign stage[i+1] = maskAmt[i] ? (stage[i] >> SH) : stage[i];
  end

  assign rightMask = stage[AMT_W];

  // the left-shift mask is the right-shift mask with its bit order reversed
  for (genvar j = 0; j < WIDTH; j++) begin : g_rev
    assign leftMask[j] = rightMask[WIDTH-1-j];
  end

  assign keepMask = maskLeft ? leftMask : rightMask;
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
(
  input  logic [WIDTH-1:0] operand,
  input  shiftCtrl_t       ctrl,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] rotStage [0:AMT_W];
  logic [WIDTH-1:0] rotOut;
  logic [WIDTH-1:0] keepMask;
  logic [WIDTH-1:0] shiftOut;

  assign rotStage[0] = operand;

  // the cascade moves bits rightward only: stage i rotates by 2**i
  for (genvar i = 0; i < AMT_W; i++) begin : g_rstage
    localparam int SH = 1 << i;
    assign rotStage[i+1] = ctrl.coreAmt[i]
      ? {rotStage[i][SH-1:0], rotStage[i][WIDTH-1:SH]}
      : rotStage[i];
  end

  // fixed one-lane right step that completes 32 - K for left moves
  assign rotOut = ctrl.extraRot
    ? {rotStage[AMT_W][0], rotStage[AMT_W][WIDTH-1:1]}
    : rotStage[AMT_W];

  shift_maskgen i_maskgen (
    .maskAmt  (ctrl.maskAmt),
    .maskLeft (ctrl.maskLeft),
    .keepMask (keepMask)
  );

  assign shiftOut = (rotOut & keepMask) | ({WIDTH{ctrl.signFill}} & ~keepMask);
  assign result   = ctrl.takeRotate ? rotOut : shiftOut;

  // R7: the cascade never creates or drops a one bit
  always_comb begin
    assert_rot_popcount_R7: assert ($countones(rotOut) == $countones(operand))
      else $error("rotate path changed the number of one bits");
  end

  // R6: a zero distance keeps every lane of the shift mask
  always_comb begin
    if (ctrl.maskAmt == '0)
      assert_mask_full_R6: assert (keepMask == '1)
        else $error("mask not full at zero distance");
  end
endmodule

// File: rtl/rot_barrel_shifter.sv
module rot_barrel_shifter
  import shift_pkg::*;
(
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] amount,
  input  logic             rotSel,
  input  logic             dirLeft,
  input  logic             arith,
  output logic [WIDTH-1:0] result
);
  shiftCtrl_t ctrl;

  shift_ctrl i_ctrl (
    .amount  (amount),
    .rotSel  (rotSel),
    .dirLeft (dirLeft),
    .arith   (arith),
    .signBit (operand[WIDTH-1]),
    .ctrl    (ctrl)
  );

  shift_datapath i_datapath (
    .operand (operand),
    .ctrl    (ctrl),
    .result  (result)
  );

  // R6: a zero distance passes the operand for every operation
  always_comb begin
    if (amount == '0)
      assert_zero_pass_R6: assert (result == operand)
        else $error("zero distance altered the operand");
  end

  // R3: a logical right shift clears the top lane
  always_comb begin
    if (!rotSel && !dirLeft && !arith && amount != '0)
      assert_srl_top_zero_R3: assert (result[WIDTH-1] == 1'b0)
        else $error("logical right shift left a one in the top lane");
  end

  // R4: an arithmetic right shift keeps the sign in the top lane
  always_comb begin
    if (!rotSel && !dirLeft && arith)
      assert_sra_sign_R4: assert (result[WIDTH-1] == operand[WIDTH-1])
        else $error("arithmetic right shift lost the sign");
  end

  // R5: a left shift clears the bottom lane
  always_comb begin
    if (!rotSel && dirLeft && amount != '0)
      assert_sll_low_zero_R5: assert (result[0] == 1'b0)
        else $error("left shift left a one in the bottom lane");
  end

  // R7: both rotation directions keep the population count
  always_comb begin
    if (rotSel)
      assert_rot_ones_R7: assert ($countones(result) == $countones(operand))
        else $error("rotation changed the number of one bits");
  end
endmodule

// File: tb/test_rot_barrel_shifter.sv
module test_rot_barrel_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] operand;
  logic [4:0]  amount;
  logic        rotSel, dirLeft, arith;
  logic [31:0] result;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_barrel_shifter i_rot_barrel_shifter (
    .operand (operand),
    .amount  (amount),
    .rotSel  (rotSel),
    .dirLeft (dirLeft),
    .arith   (arith),
    .result  (result)
  );

  // op: 0 ror, 1 rol, 2 sll, 3 srl, 4 sra
  function automatic logic [31:0] model(int op, logic [31:0] x, int k);
    case (op)
      0: return (x >> k) | (x << (32 - k));
      1: return (x << k) | (x >> (32 - k));
      2: return x << k;
      3: return x >> k;
      default: return $unsigned($signed(x) >>> k);
    endcase
  endfunction

  function automatic string reqOf(int op, int k);
    if (k == 0) return "R6";
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R5";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d%0d%0d k=%0d x=%h actual=%h expected=%h",
               req, rotSel, dirLeft, arith, amount, operand, result, exp);
    end
  endtask

  // drive at the rising edge, sample the combinational result at the falling edge (R9)
  task automatic runOne(int op, logic [31:0] x, int k, logic arithForce);
    @(posedge clk);
    operand = x;
    amount  = k[4:0];
    rotSel  = (op <= 1);
    dirLeft = (op == 1 || op == 2);
    arith   = (op == 4) ? 1'b1 : arithForce;
    @(negedge clk);
    check(reqOf(op, k), model(op, x, k));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] dir [5];
    dir[0] = 32'h0000_0000; dir[1] = 32'hFFFF_FFFF; dir[2] = 32'h8000_0000;
    dir[3] = 32'h0000_0001; dir[4] = 32'h7FFF_FFFF;
    seed = $urandom(32'd1234);
    operand = '0; amount = '0; rotSel = 1'b0; dirLeft = 1'b0; arith = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset state", 32'h0);
    rstN = 1'b1;

    // directed corners: every op, every distance (R1..R6, R9)
    for (int p = 0; p < 5; p++)
      for (int op = 0; op < 5; op++)
        for (int k = 0; k < 32; k++)
          runOne(op, dir[p], k, 1'b0);

    // constrained random operands, every op and distance
    for (int n = 0; n < 20; n++)
      for (int op = 0; op < 5; op++)
        for (int k = 0; k < 32; k++)
          runOne(op, $urandom(), k, 1'b0);

    // R8: arith set on rotations and left shifts must change nothing
    for (int n = 0; n < 10; n++)
      for (int op = 0; op < 3; op++)
        for (int k = 0; k < 32; k++) begin
          logic [31:0] x;
          x = $urandom() | 32'h8000_0000;
          runOne(op, x, k, 1'b1);
          check("R8 arith ignored", model(op, x, k));
        end

    // R7: popcount of rotations, signed operand
    runOne(0, 32'hF000_000F, 7, 1'b0);
    checks++;
    if ($countones(result) != 8) begin
      fails++;
      $display("FAIL R7 actual=%0d expected=8", $countones(result));
    end
    runOne(1, 32'h8421_0001, 13, 1'b0);
    checks++;
    if ($countones(result) != 5) begin
      fails++;
      $display("FAIL R7 actual=%0d expected=5", $countones(result));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule